// File: doc/BRIEF.md
# USB Line Transceiver Control Core

This block is the digital control core of a low/full-speed USB line transceiver, with the analog front end abstracted away. The system side has a pair of data lines (VP/VM) that work in both directions. They are modelled as separate input values, output values and a shared output enable. The system side also has a single-ended received-data output and the control inputs for direction, input encoding, suspend, speed and attach. Each bus line (D+ and D-) is modelled as a drive value, a drive enable and a sampled input. Two outputs select which bus line the 1.5 kOhm pull-up is attached to.

In transmit, the block turns system data into a bus line state. It uses one of two encodings: a differential pair or a single-ended data bit with an SE0 override. In receive, it passes the synchronized bus lines to the system side and decodes a received-data bit. That bit keeps its last J/K value through SE0 and through the invalid both-high state. Suspend releases the bus, forces the received bit low and turns the system lines into outputs. Two power-good inputs model a missing system-side or bus-side supply. When either supply is missing, the bus is released.

Top module: `usb_xcvr_ctrl`

## Requirements
- R1: With `oe_rx_i`=0, `susp_i`=0 and both power-good inputs high, `dpdm_oe_o`=1 and `vpvm_oe_o`=0.
- R2: With `oe_rx_i`=1, `dpdm_oe_o`=0 and `vpvm_oe_o`=1. `vp_o`/`vm_o` equal `dp_i`/`dm_i` after a two-stage synchronizer: a bus value held for 2 clock edges appears at the outputs.
- R3: With `mode_i`=1 while driving, `dp_o`=`vp_i` and `dm_o`=`vm_i`. `vp_i`=`vm_i`=1 raises `undef_o`.
- R4: With `mode_i`=0 while driving, `vm_i`=1 gives `dp_o`=`dm_o`=0 (SE0). `vm_i`=0 gives `dp_o`=`vp_i` and `dm_o`=!`vp_i`. `undef_o` stays 0.
- R5: The received bit becomes 1 for the synchronized bus state D+=1,D-=0 (J) and 0 for D+=0,D-=1 (K). It is visible on `rcv_o` one edge after the synchronizer output.
- R6: While the synchronized bus is SE0 (both lines 0), `rcv_o` keeps the value it had before SE0 began, and this continues after SE0 ends.
- R7: When not driving and both synchronized bus lines are 1, `undef_o`=1 and `rcv_o` keeps its previous value.
- R8: With `susp_i`=1, `dpdm_oe_o`=0, `rcv_o`=0 and `vpvm_oe_o`=1, whatever the value of `oe_rx_i`.
- R9: `enum_i`=0 gives `pu_dp_o`=`pu_dm_o`=0. With `enum_i`=1, `speed_i`=1 sets only `pu_dp_o` and `speed_i`=0 sets only `pu_dm_o`. This holds in suspend as well.
- R10: If `sys_pwr_ok_i` or `bus_pwr_ok_i` is 0, `dpdm_oe_o`=0.
- R11: `dpdm_oe_o` and `vpvm_oe_o` are never 1 in the same cycle.
- R12: After reset, `rcv_o`=0 and the synchronized bus reads SE0 (`vp_o`=`vm_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1: differential transmit input, 0: single-ended |
| oe_rx_i | input | 1 | 0: transmit, 1: receive |
| susp_i | input | 1 | Suspend request |
| speed_i | input | 1 | 1: full speed (pull-up on D+), 0: low speed (pull-up on D-) |
| enum_i | input | 1 | Pull-up attach enable |
| sys_pwr_ok_i | input | 1 | System-side supply present |
| bus_pwr_ok_i | input | 1 | Bus-side supply present |
| vp_i | input | 1 | System VP value driven into the block |
| vm_i | input | 1 | System VM value driven into the block |
| vp_o | output | 1 | VP value driven by the block |
| vm_o | output | 1 | VM value driven by the block |
| vpvm_oe_o | output | 1 | Block drives VP/VM |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| dpdm_oe_o | output | 1 | D+/D- drive enable |
| rcv_o | output | 1 | Received data bit |
| undef_o | output | 1 | Undefined (both-high) line state flag |
| pu_dp_o | output | 1 | Pull-up attached to D+ |
| pu_dm_o | output | 1 | Pull-up attached to D- |

## Verification
The bench targets the received-bit hold in three places: across SE0 entry and exit, across the both-high state, and through suspend. A design that reloads the hold register on SE0 would drop the bit to 0. A design that gates the register with suspend would lose the bit after suspend ends. The single-ended SE0 override is swept with both VP values, so an encoder that lets VP through while VM is high drives a J or K instead of SE0. Suspend and power loss are applied with a transmit request present. Any decode that gives direction priority over them would drive the bus and the system lines together.

// File: rtl/usb_xcvr_pkg.sv
package usb_xcvr_pkg;
  // bit 1 = D+, bit 0 = D-
  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_K   = 2'b01,
    LINE_J   = 2'b10,
    LINE_SE1 = 2'b11
  } line_e;
endpackage

// File: rtl/usb_tx_encoder.sv
module usb_tx_encoder
  import usb_xcvr_pkg::*;
(
  input  logic mode_i,
  input  logic vp_i,
  input  logic vm_i,
  output line_e line_o,
  output logic undef_o
);
  always_comb begin
    if (mode_i) begin
      line_o  = line_e'({vp_i, vm_i});
      undef_o = vp_i & vm_i;
    end else begin
      line_o  = vm_i ? LINE_SE0 : (vp_i ? LINE_J : LINE_K);
      undef_o = 1'b0;
    end
  end
endmodule

// File: rtl/usb_rx_decoder.sv
module usb_rx_decoder
  import usb_xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_e line_o,
  output logic  rcv_q_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] dp_sh, dm_sh;
  logic          rcv_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dp_sh <= '0;
          dm_sh <= '0;
        end else begin
          dp_sh <= dp_i;
          dm_sh <= dm_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dp_sh <= '0;
          dm_sh <= '0;
        end else begin
          dp_sh <= {dp_sh[LAST-1:0], dp_i};
          dm_sh <= {dm_sh[LAST-1:0], dm_i};
        end
      end
    end
  endgenerate

  assign line_o = line_e'({dp_sh[LAST], dm_sh[LAST]});

  // hold register: only J/K reload it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rcv_q <= 1'b0;
    else if (line_o == LINE_J || line_o == LINE_K) rcv_q <= dp_sh[LAST];
  end

  assign rcv_q_o = rcv_q;

  assert_rcv_j_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o == LINE_J |=> rcv_q);
  assert_rcv_k_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o == LINE_K |=> !rcv_q);
  assert_se0_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o == LINE_SE0 |=> $stable(rcv_q));
  assert_se1_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o == LINE_SE1 |=> $stable(rcv_q));
endmodule

// File: rtl/usb_pullup_steer.sv
module usb_pullup_steer (
  input  logic enum_i,
  input  logic speed_i,
  output logic pu_dp_o,
  output logic pu_dm_o
);
  assign pu_dp_o = enum_i &  speed_i;
  assign pu_dm_o = enum_i & ~speed_i;
endmodule

// File: rtl/usb_xcvr_ctrl.sv
module usb_xcvr_ctrl
  import usb_xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic oe_rx_i,
  input  logic susp_i,
  input  logic speed_i,
  input  logic enum_i,
  input  logic sys_pwr_ok_i,
  input  logic bus_pwr_ok_i,
  input  logic vp_i,
  input  logic vm_i,
  output logic vp_o,
  output logic vm_o,
  output logic vpvm_oe_o,
  input  logic dp_i,
  input  logic dm_i,
  output logic dp_o,
  output logic dm_o,
  output logic dpdm_oe_o,
  output logic rcv_o,
  output logic undef_o,
  output logic pu_dp_o,
  output logic pu_dm_o
);
  line_e tx_line, rx_line;
  logic  tx_undef, rcv_q, tx_drive;

  usb_tx_encoder u_tx (
    .mode_i (mode_i),
    .vp_i   (vp_i),
    .vm_i   (vm_i),
    .line_o (tx_line),
    .undef_o(tx_undef)
  );

  usb_rx_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dp_i   (dp_i),
    .dm_i   (dm_i),
    .line_o (rx_line),
    .rcv_q_o(rcv_q)
  );

  usb_pullup_steer u_pu (
    .enum_i (enum_i),
    .speed_i(speed_i),
    .pu_dp_o(pu_dp_o),
    .pu_dm_o(pu_dm_o)
  );

  // suspend and supply loss override direction
  assign tx_drive  = ~oe_rx_i & ~susp_i & sys_pwr_ok_i & bus_pwr_ok_i;
  assign dpdm_oe_o = tx_drive;
  assign vpvm_oe_o = oe_rx_i | susp_i;
  assign dp_o      = tx_drive & tx_line[1];
  assign dm_o      = tx_drive & tx_line[0];
  assign vp_o      = rx_line[1];
  assign vm_o      = rx_line[0];
  assign rcv_o     = ~susp_i & rcv_q;
  assign undef_o   = tx_drive ? tx_undef : (rx_line == LINE_SE1);

  assert_oe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dpdm_oe_o && vpvm_oe_o));
  assert_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i |-> (!dpdm_oe_o && !rcv_o && vpvm_oe_o));
  assert_pwr_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_pwr_ok_i && bus_pwr_ok_i) |-> !dpdm_oe_o);
  assert_se_no_se1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dpdm_oe_o && !mode_i) |-> !(dp_o && dm_o));
  assert_pu_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pu_dp_o && pu_dm_o) && (enum_i || (!pu_dp_o && !pu_dm_o)));
endmodule

// File: tb/usb_xcvr_ctrl_tb.sv
module usb_xcvr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode, oe_rx, susp, speed, enm, sys_ok, bus_ok, vp, vm, dp, dm;
  logic vp_o, vm_o, vpvm_oe, dp_o, dm_o, dpdm_oe, rcv, undef, pu_dp, pu_dm;
  int checks = 0, fails = 0;
  logic rcv_m = 1'b0;

  always #5 clk = ~clk;

  usb_xcvr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_rx_i(oe_rx), .susp_i(susp),
    .speed_i(speed), .enum_i(enm), .sys_pwr_ok_i(sys_ok), .bus_pwr_ok_i(bus_ok),
    .vp_i(vp), .vm_i(vm), .vp_o(vp_o), .vm_o(vm_o), .vpvm_oe_o(vpvm_oe),
    .dp_i(dp), .dm_i(dm), .dp_o(dp_o), .dm_o(dm_o), .dpdm_oe_o(dpdm_oe),
    .rcv_o(rcv), .undef_o(undef), .pu_dp_o(pu_dp), .pu_dm_o(pu_dm)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] enc(input logic md, input logic p, input logic m);
    if (md) return {p, m};
    if (m)  return 2'b00;
    return {p, ~p};
  endfunction

  // apply, let sync + hold register settle, sample at negedge
  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (dp != dm) rcv_m = dp;
  endtask

  task automatic check_all();
    logic drv;
    logic [1:0] ln;
    drv = !oe_rx && !susp && sys_ok && bus_ok;
    ln  = enc(mode, vp, vm);
    check("R1_R10 dpdm_oe", dpdm_oe, drv);
    check("R2_R8 vpvm_oe", vpvm_oe, oe_rx || susp);
    check("R11 excl", dpdm_oe && vpvm_oe, 1'b0);
    if (drv) begin
      check(mode ? "R3 dp" : "R4 dp", dp_o, ln[1]);
      check(mode ? "R3 dm" : "R4 dm", dm_o, ln[0]);
      check(mode ? "R3 undef" : "R4 undef", undef, mode && vp && vm);
    end else begin
      check("R7 undef", undef, dp && dm);
    end
    check("R2 vp_o", vp_o, dp);
    check("R2 vm_o", vm_o, dm);
    check("R5_R6_R8 rcv", rcv, susp ? 1'b0 : rcv_m);
    check("R9 pu_dp", pu_dp, enm && speed);
    check("R9 pu_dm", pu_dm, enm && !speed);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    {mode, oe_rx, susp, speed, enm, vp, vm} = '0;
    sys_ok = 1'b1; bus_ok = 1'b1;
    dp = 1'b1; dm = 1'b1;
    #1;
    // R12: reset state, bus input ignored while in reset
    check("R12 rcv", rcv, 1'b0);
    check("R12 vp_o", vp_o, 1'b0);
    check("R12 vm_o", vm_o, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    dp = 1'b0; dm = 1'b0;
    settle();
    check_all();

    // sweep control combinations with random data
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      {mode, oe_rx, susp, enm, speed} = 5'(i % 32);
      vp = 1'($urandom); vm = 1'($urandom);
      dp = 1'($urandom); dm = 1'($urandom);
      sys_ok = ($urandom % 8) != 0;
      bus_ok = ($urandom % 8) != 0;
      settle();
      check_all();
    end

    // directed: SE0 hold after J and after K, exit into the same state
    {mode, oe_rx, susp, sys_ok, bus_ok} = 5'b01011;
    dp = 1'b1; dm = 1'b0; settle();
    check("R5 rcv J", rcv, 1'b1);
    dp = 1'b0; dm = 1'b0; settle();
    check("R6 rcv hold 1 in SE0", rcv, 1'b1);
    dp = 1'b1; dm = 1'b1; settle();
    check("R7 rcv hold in SE1", rcv, 1'b1);
    check("R7 undef rx", undef, 1'b1);
    dp = 1'b0; dm = 1'b1; settle();
    check("R5 rcv K", rcv, 1'b0);
    dp = 1'b0; dm = 1'b0; settle();
    check("R6 rcv hold 0 in SE0", rcv, 1'b0);
    dp = 1'b1; dm = 1'b0; settle();
    check("R6 rcv after SE0 exit", rcv, 1'b1);
    // suspend forces 0, hold survives it
    susp = 1'b1; dp = 1'b0; dm = 1'b0; settle();
    check("R8 rcv suspended", rcv, 1'b0);
    susp = 1'b0; settle();
    check("R6 rcv after suspend", rcv, 1'b1);
    // transmit with supply loss
    oe_rx = 1'b0; mode = 1'b0; vp = 1'b1; vm = 1'b0;
    bus_ok = 1'b0; settle();
    check("R10 bus supply off", dpdm_oe, 1'b0);
    bus_ok = 1'b1; sys_ok = 1'b0; settle();
    check("R10 sys supply off", dpdm_oe, 1'b0);
    sys_ok = 1'b1; vm = 1'b1; settle();
    check("R4 SE0 force dp", dp_o, 1'b0);
    check("R4 SE0 force dm", dm_o, 1'b0);
    check_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule